// File: doc/BRIEF.md
# Double-Buffered Stage Latches with Halt Detection

This block holds the three inter-stage latches of a three-stage in-order core: fetch to decode, decode to execute, and execute to writeback. There is exactly one writeback latch. Each latch has two halves. The producer writes the tail half and the consumer reads the head half. At every clock edge the halves trade roles, unless the stage's stall input holds them in place. Because work in a stalled latch sits in the tail rather than the head, each latch reports a pending flag. The flag follows the tail half while the latch is stalled and the head half otherwise.

The halt detector combines the three pending flags with several other inputs: a fetch-halted indication, an exception-in-progress indication, and an occupancy tracker for the execute unit. The tracker counts the execute unit's in-flight queue and its parked-operation queue. The registered `halted` output rises only when every source of outstanding work is gone. A long operation such as a divide that sits in execute therefore keeps the core alive, even when every latch head looks empty.

Each latch edge follows valid/ready rules. A write is taken when `in_valid` and `in_ready` are both high. `in_ready` drops only while the latch is stalled and its tail already holds an entry. A read is taken when `out_valid` and `out_ready` are both high. The consumer must take the head in every cycle in which the latch is not stalled; otherwise the entry rotates back into the tail and may be overwritten.

Top module: `pipe_latch_halt`

## Requirements
- R1: With no stall, a word accepted on `in_data` at a clock edge appears on `out_data` with `out_valid` high just after that edge, so that back-to-back words stream one per cycle.
- R2: While a latch's stall input is high, its head half does not move: `out_data` and `out_valid` stay as they were, apart from a consume.
- R3: `pend_valid` shows the tail half's occupancy while the latch is stalled and the head half's occupancy otherwise.
- R4: A consume (`out_valid` and `out_ready` high at an edge) clears the head entry. In a stalled latch, `out_valid` is low after that edge.
- R5: A flush clears both halves at the same edge and takes priority over a write in that cycle.
- R6: `in_ready` is low while the latch is stalled with an occupied tail. A write offered then is dropped and never reaches the head.
- R7: `exec_empty` is high only when both the in-flight count and the parked count are zero. A pop of a queue whose count is zero leaves its count at zero.
- R8: `halted` rises one edge after a cycle in which fetch has halted, no exception is active, `exec_empty` is high and all three `pend_valid` bits are low.
- R9: Once high, `halted` stays high until reset.
- R10: Work in a stalled tail, an exception in progress, or a busy execute unit (for example a 39-cycle divide) keeps `halted` low even when fetch has halted and all heads are empty.
- R11: After reset, all latches are empty, `in_ready` is high, `exec_empty` is high and `halted` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| link_stall | input | 3 | Per-latch stall (bit 0 fetch/decode, 1 decode/execute, 2 execute/writeback) |
| link_flush | input | 3 | Per-latch flush of both halves |
| in_valid | input | 3 | Producer offers a word to the tail |
| in_data | input | 3×DATA_W | Producer words, one per latch |
| in_ready | output | 3 | Tail can take a word |
| out_valid | output | 3 | Head holds a word |
| out_data | output | 3×DATA_W | Head words |
| out_ready | input | 3 | Consumer takes the head word |
| pend_valid | output | 3 | Pending half occupied |
| ex_pipe_push | input | 1 | Operation enters execute in-flight queue |
| ex_pipe_pop | input | 1 | Operation leaves in-flight queue |
| ex_park_push | input | 1 | Operation enters parked queue |
| ex_park_pop | input | 1 | Operation leaves parked queue |
| exec_empty | output | 1 | Both execute queues empty |
| fetch_halted | input | 1 | Fetch stage has stopped |
| exc_active | input | 1 | Exception handling in progress |
| halted | output | 1 | Core has truly halted (sticky) |

## Verification
Two things can happen at the same clock edge: a latch's stall can be released while the fetch-halted input is high, and a consume and a write can hit one latch together. The bench drives a stalled latch whose head is consumed while its tail still holds work, and judges that `pend_valid` stays high and `halted` stays low. It then releases the stall with fetch still running, drains the head, and expects `halted` exactly one edge after the last pending bit falls. The flush-with-write collision is provoked on a stalled latch whose halves are both full, and is judged by `out_valid` and `pend_valid` both being low afterwards.

// File: rtl/plh_pkg.sv
package plh_pkg;
  localparam int unsigned NUM_LINKS = 3;
  localparam int unsigned NUM_EXQ   = 2;

  typedef enum logic [1:0] {
    LINK_FD = 2'd0,
    LINK_DX = 2'd1,
    LINK_XW = 2'd2
  } link_e;

  typedef enum logic {
    EXQ_PIPE = 1'b0,
    EXQ_PARK = 1'b1
  } exq_e;
endpackage

// File: rtl/plh_latch.sv
module plh_latch #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stall,
  input  logic              flush,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  input  logic              out_ready,
  output logic              pend_valid
);
  localparam int unsigned HALVES = 2;

  logic                hsel;
  logic [HALVES-1:0]   occ;
  logic [DATA_W-1:0]   word [HALVES];
  logic                head_idx;
  logic                tail_idx;
  logic                wr_fire;
  logic                rd_fire;

  assign head_idx   = hsel;
  assign tail_idx   = ~hsel;
  assign in_ready   = ~(stall & occ[tail_idx]);
  assign wr_fire    = in_valid & in_ready & ~flush;
  assign out_valid  = occ[head_idx];
  assign out_data   = word[head_idx];
  assign rd_fire    = out_valid & out_ready;
  assign pend_valid = stall ? occ[tail_idx] : occ[head_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hsel <= 1'b0;
      occ  <= '0;
    end else begin
      if (flush) begin
        occ <= '0;
      end else begin
        if (wr_fire) occ[tail_idx] <= 1'b1;
        if (rd_fire) occ[head_idx] <= 1'b0;
      end
      if (!stall) hsel <= ~hsel;
    end
  end

  for (genvar g = 0; g < HALVES; g++) begin : g_half
    always_ff @(posedge clk) begin
      if (wr_fire && (tail_idx == 1'(g))) word[g] <= in_data;
    end
  end
endmodule

// File: rtl/plh_exec_track.sv
module plh_exec_track #(
  parameter int unsigned CNT_W = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pipe_push,
  input  logic pipe_pop,
  input  logic park_push,
  input  logic park_pop,
  output logic exec_empty
);
  import plh_pkg::*;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [NUM_EXQ-1:0] push_v;
  logic [NUM_EXQ-1:0] pop_v;
  logic [NUM_EXQ-1:0] busy;

  assign push_v[EXQ_PIPE] = pipe_push;
  assign pop_v[EXQ_PIPE]  = pipe_pop;
  assign push_v[EXQ_PARK] = park_push;
  assign pop_v[EXQ_PARK]  = park_pop;

  for (genvar q = 0; q < NUM_EXQ; q++) begin : g_q
    logic [CNT_W-1:0] cnt;
    logic             inc;
    logic             dec;
    assign inc = push_v[q] & ~pop_v[q] & (cnt != CNT_MAX);
    assign dec = pop_v[q] & ~push_v[q] & (cnt != '0);
    always_ff @(posedge clk) begin
      if (!rst_n)   cnt <= '0;
      else if (inc) cnt <= cnt + 1'b1;
      else if (dec) cnt <= cnt - 1'b1;
    end
    assign busy[q] = (cnt != '0);
  end

  assign exec_empty = ~|busy;
endmodule

// File: rtl/plh_halt.sv
module plh_halt #(
  parameter int unsigned N_LINKS = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fetch_halted,
  input  logic               exc_active,
  input  logic               exec_empty,
  input  logic [N_LINKS-1:0] pend_valid,
  output logic               halted
);
  logic quiet;
  assign quiet = fetch_halted & ~exc_active & exec_empty & ~|pend_valid;

  always_ff @(posedge clk) begin
    if (!rst_n)     halted <= 1'b0;
    else if (quiet) halted <= 1'b1;
  end
endmodule

// File: rtl/pipe_latch_halt.sv
module pipe_latch_halt
  import plh_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 6
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [NUM_LINKS-1:0]             link_stall,
  input  logic [NUM_LINKS-1:0]             link_flush,
  input  logic [NUM_LINKS-1:0]             in_valid,
  input  logic [NUM_LINKS-1:0][DATA_W-1:0] in_data,
  output logic [NUM_LINKS-1:0]             in_ready,
  output logic [NUM_LINKS-1:0]             out_valid,
  output logic [NUM_LINKS-1:0][DATA_W-1:0] out_data,
  input  logic [NUM_LINKS-1:0]             out_ready,
  output logic [NUM_LINKS-1:0]             pend_valid,
  input  logic                             ex_pipe_push,
  input  logic                             ex_pipe_pop,
  input  logic                             ex_park_push,
  input  logic                             ex_park_pop,
  output logic                             exec_empty,
  input  logic                             fetch_halted,
  input  logic                             exc_active,
  output logic                             halted
);
  for (genvar l = 0; l < NUM_LINKS; l++) begin : g_link
    plh_latch #(.DATA_W(DATA_W)) u_latch (
      .clk        (clk),
      .rst_n      (rst_n),
      .stall      (link_stall[l]),
      .flush      (link_flush[l]),
      .in_valid   (in_valid[l]),
      .in_data    (in_data[l]),
      .in_ready   (in_ready[l]),
      .out_valid  (out_valid[l]),
      .out_data   (out_data[l]),
      .out_ready  (out_ready[l]),
      .pend_valid (pend_valid[l])
    );
  end

  plh_exec_track #(.CNT_W(CNT_W)) u_exec (
    .clk        (clk),
    .rst_n      (rst_n),
    .pipe_push  (ex_pipe_push),
    .pipe_pop   (ex_pipe_pop),
    .park_push  (ex_park_push),
    .park_pop   (ex_park_pop),
    .exec_empty (exec_empty)
  );

  plh_halt #(.N_LINKS(NUM_LINKS)) u_halt (
    .clk          (clk),
    .rst_n        (rst_n),
    .fetch_halted (fetch_halted),
    .exc_active   (exc_active),
    .exec_empty   (exec_empty),
    .pend_valid   (pend_valid),
    .halted       (halted)
  );
endmodule

// File: rtl/plh_checker.sv
module plh_checker #(
  parameter int unsigned N      = 3,
  parameter int unsigned DATA_W = 32
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [N-1:0]             link_stall,
  input logic [N-1:0]             link_flush,
  input logic [N-1:0]             in_valid,
  input logic [N-1:0][DATA_W-1:0] in_data,
  input logic [N-1:0]             in_ready,
  input logic [N-1:0]             out_valid,
  input logic [N-1:0][DATA_W-1:0] out_data,
  input logic [N-1:0]             out_ready,
  input logic [N-1:0]             pend_valid,
  input logic                     ex_pipe_pop,
  input logic                     ex_park_pop,
  input logic                     exec_empty,
  input logic                     fetch_halted,
  input logic                     exc_active,
  input logic                     halted
);
  for (genvar l = 0; l < N; l++) begin : g_chk
    p_stream_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid[l] && in_ready[l] && !link_stall[l] && !link_flush[l])
      |=> (out_valid[l] && out_data[l] == $past(in_data[l])));
    p_stall_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      link_stall[l] |=> $stable(out_data[l]));
    p_consume_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid[l] && out_ready[l] && link_stall[l]) |=> !out_valid[l]);
    p_flush_r5: assert property (@(posedge clk) disable iff (!rst_n)
      link_flush[l] |=> (!out_valid[l] && !pend_valid[l]));
    p_backpress_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (link_stall[l] && pend_valid[l]) |-> !in_ready[l]);
  end

  p_exec_drain_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(exec_empty) |-> $past(ex_pipe_pop || ex_park_pop));
  p_halt_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halted) |-> $past(fetch_halted && !exc_active && exec_empty && (pend_valid == '0)));
  p_halt_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);
endmodule

bind pipe_latch_halt plh_checker #(.N(plh_pkg::NUM_LINKS), .DATA_W(DATA_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .link_stall   (link_stall),
  .link_flush   (link_flush),
  .in_valid     (in_valid),
  .in_data      (in_data),
  .in_ready     (in_ready),
  .out_valid    (out_valid),
  .out_data     (out_data),
  .out_ready    (out_ready),
  .pend_valid   (pend_valid),
  .ex_pipe_pop  (ex_pipe_pop),
  .ex_park_pop  (ex_park_pop),
  .exec_empty   (exec_empty),
  .fetch_halted (fetch_halted),
  .exc_active   (exc_active),
  .halted       (halted)
);

// File: tb/pipe_latch_halt_test.sv
module pipe_latch_halt_test;
  localparam int DW = 32;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [2:0]        link_stall, link_flush, in_valid, in_ready, out_valid, out_ready, pend_valid;
  logic [2:0][DW-1:0] in_data, out_data;
  logic ex_pipe_push, ex_pipe_pop, ex_park_push, ex_park_pop, exec_empty;
  logic fetch_halted, exc_active, halted;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  bit mon_en = 1'b0;
  logic [DW-1:0] exp_q [$];

  always #5 clk = ~clk;

  pipe_latch_halt #(.DATA_W(DW), .CNT_W(6)) uut (
    .clk(clk), .rst_n(rst_n), .link_stall(link_stall), .link_flush(link_flush),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
    .pend_valid(pend_valid), .ex_pipe_push(ex_pipe_push), .ex_pipe_pop(ex_pipe_pop),
    .ex_park_push(ex_park_push), .ex_park_pop(ex_park_pop), .exec_empty(exec_empty),
    .fetch_halted(fetch_halted), .exc_active(exc_active), .halted(halted)
  );

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  // Scoreboard monitor on the fetch/decode latch (R1)
  always @(posedge clk) begin
    #2;
    if (mon_en && out_valid[0] && out_ready[0]) begin
      if (exp_q.size() == 0) chk("R1 unexpected word", out_data[0], 32'hDEAD);
      else chk("R1 stream word", out_data[0], exp_q.pop_front());
    end
  end

  task automatic push0(input logic [DW-1:0] d);
    in_valid[0] = 1'b1;
    in_data[0]  = d;
    exp_q.push_back(d);
    step();
    in_valid[0] = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; link_stall = '0; link_flush = '0; in_valid = '0; out_ready = '0;
    in_data = '0; ex_pipe_push = 0; ex_pipe_pop = 0; ex_park_push = 0; ex_park_pop = 0;
    fetch_halted = 0; exc_active = 0;
    step(); step();
    rst_n = 1'b1;
    step();
    // R11 reset state
    chk("R11 out_valid", {29'b0, out_valid}, 0);
    chk("R11 in_ready", {29'b0, in_ready}, 32'h7);
    chk("R11 pend_valid", {29'b0, pend_valid}, 0);
    chk("R11 exec_empty", {31'b0, exec_empty}, 1);
    chk("R11 halted", {31'b0, halted}, 0);

    // R1 streaming through latch 0 with scoreboard
    mon_en = 1'b1; out_ready[0] = 1'b1;
    for (int i = 0; i < 5; i++) push0(32'hA000 + i);
    step();
    push0(32'hB001);
    step(); step();
    push0(32'hB002);
    push0(32'hB003);
    step(); step();
    chk("R1 scoreboard drained", exp_q.size(), 0);
    mon_en = 1'b0; out_ready[0] = 1'b0;

    // R4 consume on latch 1
    in_valid[1] = 1'b1; in_data[1] = 32'h1111;
    step();
    in_valid[1] = 1'b0;
    chk("R1 head after write", out_data[1], 32'h1111);
    out_ready[1] = 1'b1;
    step();
    out_ready[1] = 1'b0;
    chk("R4 head cleared", {31'b0, out_valid[1]}, 0);

    // R2/R3/R6 stall behaviour on latch 1
    in_valid[1] = 1'b1; in_data[1] = 32'hAAAA;
    step();
    link_stall[1] = 1'b1; in_data[1] = 32'hBBBB;
    step();
    chk("R2 head held", out_data[1], 32'hAAAA);
    chk("R2 head valid", {31'b0, out_valid[1]}, 1);
    chk("R3 pend follows tail", {31'b0, pend_valid[1]}, 1);
    chk("R6 ready low", {31'b0, in_ready[1]}, 0);
    in_data[1] = 32'hCCCC; out_ready[1] = 1'b1;
    step();
    in_valid[1] = 1'b0; out_ready[1] = 1'b0;
    chk("R4 stalled consume clears head", {31'b0, out_valid[1]}, 0);
    chk("R3 pend tail while head empty", {31'b0, pend_valid[1]}, 1);
    link_stall[1] = 1'b0;
    step();
    chk("R6 dropped write, tail word arrives", out_data[1], 32'hBBBB);
    chk("R3 pend follows head", {31'b0, pend_valid[1]}, 1);
    out_ready[1] = 1'b1;
    step();
    out_ready[1] = 1'b0;
    chk("R4 drained", {30'b0, out_valid[1], pend_valid[1]}, 0);

    // R5 flush with both halves full and a colliding write
    in_valid[2] = 1'b1; in_data[2] = 32'h2222;
    step();
    link_stall[2] = 1'b1; in_data[2] = 32'h3333;
    step();
    chk("R5 setup both full", {30'b0, out_valid[2], pend_valid[2]}, 32'h3);
    link_flush[2] = 1'b1; in_data[2] = 32'h4444;
    step();
    in_valid[2] = 1'b0; link_flush[2] = 1'b0;
    chk("R5 flushed", {30'b0, out_valid[2], pend_valid[2]}, 0);
    link_stall[2] = 1'b0;
    step();
    chk("R5 other half empty", {30'b0, out_valid[2], pend_valid[2]}, 0);

    // R7 execute occupancy
    ex_pipe_push = 1; step(); ex_pipe_push = 0;
    chk("R7 busy pipe", {31'b0, exec_empty}, 0);
    ex_park_push = 1; ex_pipe_pop = 1; step(); ex_park_push = 0; ex_pipe_pop = 0;
    chk("R7 busy park", {31'b0, exec_empty}, 0);
    ex_park_pop = 1; step(); ex_park_pop = 0;
    chk("R7 empty", {31'b0, exec_empty}, 1);
    ex_pipe_pop = 1; step(); ex_pipe_pop = 0;
    chk("R7 pop at zero", {31'b0, exec_empty}, 1);
    ex_pipe_push = 1; step(); ex_pipe_push = 0;
    chk("R7 no underflow wrap", {31'b0, exec_empty}, 0);
    ex_pipe_pop = 1; step(); ex_pipe_pop = 0;
    chk("R7 empty again", {31'b0, exec_empty}, 1);

    // R10 long divide in execute
    ex_pipe_push = 1; step(); ex_pipe_push = 0;
    fetch_halted = 1;
    begin
      bit seen = 0;
      for (int i = 0; i < 39; i++) begin step(); if (halted) seen = 1; end
      chk("R10 divide keeps core alive", {31'b0, seen}, 0);
    end
    exc_active = 1; ex_pipe_pop = 1; step(); ex_pipe_pop = 0;
    step(); step();
    chk("R10 exception keeps core alive", {31'b0, halted}, 0);
    link_stall[0] = 1'b1; in_valid[0] = 1'b1; in_data[0] = 32'h5555;
    step();
    in_valid[0] = 1'b0; exc_active = 0;
    step(); step(); step();
    chk("R10 stalled tail keeps core alive", {31'b0, halted}, 0);
    chk("R3 stalled tail pending", {31'b0, pend_valid[0]}, 1);
    fetch_halted = 0; link_stall[0] = 1'b0;
    step();
    out_ready[0] = 1'b1;
    step();
    out_ready[0] = 1'b0; fetch_halted = 1;
    chk("R8 not yet halted", {31'b0, halted}, 0);
    step();
    chk("R8 halted after quiet cycle", {31'b0, halted}, 1);

    // R9 sticky
    fetch_halted = 0; in_valid[1] = 1'b1; in_data[1] = 32'h6666;
    step();
    in_valid[1] = 1'b0;
    chk("R9 stays halted", {31'b0, halted}, 1);
    rst_n = 1'b0;
    step();
    rst_n = 1'b1;
    chk("R9 cleared by reset", {31'b0, halted}, 0);
    step();
    finish_run();
  end
endmodule